// File: doc/BRIEF.md
# Receive Byte Ordering Lane Aligner

This block sits behind the word aligner of a multi-lane receive path. Each cycle it takes one parallel word of `LANES` symbol lanes (each `SYM_W` bits wide, four lanes of 10 bits by default) with one control flag per lane. Its job is to make a chosen marker symbol land in lane 0. When it finds the marker in a higher lane, it does not swap lanes. Instead it inserts copies of a pad symbol just ahead of the marker. This pushes the marker and every later symbol up into the next word. From then on, the symbols that spill over the top of each word are held in a carry register and reappear in the low lanes of the following word, so no symbol is lost.

The search starts only on a rising edge of the word aligner's sync status, and it runs once. When the marker sits in lane 0 of the output, a sticky done flag rises. From that point, later markers are ignored and the chosen shift stays fixed until a synchronous reset. The block must not be combined with a rate matcher. A rate matcher adds or drops symbols, which would undo the lane order this block sets up. Output words and flags are registered, so each output appears one cycle after its input word.

Top module: `rx_lane_orderer`

## Requirements
- R1: While `rst` is high at a clock edge, `lane_data_o`, `lane_ctl_o` and `order_done_o` are all zero after that edge, whatever the inputs.
- R2: Until a rising edge of `word_sync_i` has been seen since reset, every input word is passed through unchanged, one cycle later. This holds even when a word contains the marker, and `order_done_o` stays low.
- R3: A cycle in which `word_sync_i` is high after being low in the previous cycle arms the search, and that cycle's word is searched. The arming stays in place when `word_sync_i` later drops. A high `word_sync_i` in the first cycle after reset counts as a rising edge.
- R4: Lane j occupies bits [j*SYM_W+SYM_W-1 : j*SYM_W] and flag bit j. When an armed search finds the marker in lane L > 0, the output for that word keeps lanes 0..L-1 of the input and puts the pad symbol in lanes L..LANES-1. That is LANES-L pad symbols. The marker appears in lane 0 of the next output word.
- R5: When an armed search finds the marker in lane 0, no pad is inserted, the word passes unchanged, and `order_done_o` is high with that same output word.
- R6: `order_done_o` rises together with the output word whose lane 0 holds the marker, and it stays high until reset.
- R7: After the search has completed, further marker symbols in any lane cause no new padding, and the shift amount does not change.
- R8: After padding by K symbols, each output word is the previous input word's top K lanes in lanes 0..K-1, followed by the current input's lanes 0..LANES-1-K. No symbol is lost or repeated.
- R9: Control flags move with their symbols. Inserted pad symbols carry a flag of 0.
- R10: A lane matches only when its symbol equals `ALIGN_SYM` and its control flag is 1. The marker value with a flag of 0 is treated as data.
- R11: When several lanes match in the same word, the lowest-numbered matching lane sets the shift.
- R12: A synchronous reset in the middle of a stream clears the armed state, the shift, the carry register and the done flag. After it, words pass through unchanged until the search is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous reset, active high |
| word_sync_i | input | 1 | Sync status from the word aligner; its rising edge arms the search |
| lane_data_i | input | LANES*SYM_W | Incoming word, lane 0 in the low bits |
| lane_ctl_i | input | LANES | Per-lane control flags of the incoming word |
| lane_data_o | output | LANES*SYM_W | Reordered word, registered |
| lane_ctl_o | output | LANES | Per-lane control flags of the reordered word |
| order_done_o | output | 1 | Sticky flag: marker has been placed in lane 0 |

## Verification
The marker is presented in lane 0, lane 2 and lane 3, which need zero, two and one pad symbols. It is also presented in lanes 1 and 3 of the same word, which must resolve to three pads from lane 1. Comparing these cases separates a correct pad count from an off-by-one count, and separates lowest-lane priority from highest-lane priority. Further cases check the marker value with its control flag clear, a marker before any sync rise, and markers after completion. Each of these would cause padding only if matching, arming or the run-once rule were wrong. A multi-word run after padding, with distinct symbols and mixed flags, exposes any symbol the carry register drops or duplicates. A mid-stream reset shows the fixed shift being cleared.

// File: rtl/rx_lo_pkg.sv
package rx_lo_pkg;

   // Number of pad symbols that move a marker found in lane `lane` to lane 0.
   function automatic int unsigned pads_for_lane(input int unsigned lane,
                                                 input int unsigned lanes);
      return (lane == 0) ? 0 : lanes - lane;
   endfunction

endpackage

// File: rtl/rx_lo_detect.sv
module rx_lo_detect #(
   parameter int unsigned          LANES     = 4,
   parameter int unsigned          SYM_W     = 10,
   parameter int unsigned          LW        = 2,
   parameter logic [SYM_W-1:0]     ALIGN_SYM = 10'h27C
) (
   input  logic [LANES*SYM_W-1:0]  data_i,
   input  logic [LANES-1:0]        ctl_i,
   output logic                    hit_o,
   output logic [LW-1:0]           lane_o
);

   logic [LANES-1:0] match;

   // one comparator per lane: marker value and control flag set
   for (genvar g = 0; g < LANES; g++) begin : g_cmp
      assign match[g] = ctl_i[g] && (data_i[g*SYM_W +: SYM_W] == ALIGN_SYM);
   end

   // lowest matching lane wins: scan downward so the last write is the lowest
   always_comb begin
      lane_o = '0;
      for (int j = LANES - 1; j >= 0; j--) begin
         if (match[j]) lane_o = LW'(j);
      end
   end

   assign hit_o = |match;

endmodule

// File: rtl/rx_lo_shift.sv
module rx_lo_shift #(
   parameter int unsigned          LANES   = 4,
   parameter int unsigned          SYM_W   = 10,
   parameter int unsigned          LW      = 2,
   parameter logic [SYM_W-1:0]     PAD_SYM = 10'h1A5
) (
   input  logic [LANES*SYM_W-1:0]  data_i,
   input  logic [LANES-1:0]        ctl_i,
   input  logic [LANES*SYM_W-1:0]  carry_data_i,
   input  logic [LANES-1:0]        carry_ctl_i,
   input  logic                    ins_i,       // padding word
   input  logic [LW-1:0]           lane_i,      // marker lane on a padding word
   input  logic [LW-1:0]           k_i,         // established shift
   input  logic [LW-1:0]           k_eff_i,     // shift that governs the next carry
   output logic [LANES*SYM_W-1:0]  data_o,
   output logic [LANES-1:0]        ctl_o,
   output logic [LANES*SYM_W-1:0]  carry_data_o,
   output logic [LANES-1:0]        carry_ctl_o
);

   always_comb begin
      int k;
      int lane;
      k    = int'(k_i);
      lane = int'(lane_i);
      for (int j = 0; j < int'(LANES); j++) begin
         if (ins_i) begin
            if (j < lane) begin
               data_o[j*SYM_W +: SYM_W] = data_i[j*SYM_W +: SYM_W];
               ctl_o[j]                 = ctl_i[j];
            end else begin
               data_o[j*SYM_W +: SYM_W] = PAD_SYM;
               ctl_o[j]                 = 1'b0;
            end
         end else if (j < k) begin
            data_o[j*SYM_W +: SYM_W] = carry_data_i[j*SYM_W +: SYM_W];
            ctl_o[j]                 = carry_ctl_i[j];
         end else begin
            data_o[j*SYM_W +: SYM_W] = data_i[(j-k)*SYM_W +: SYM_W];
            ctl_o[j]                 = ctl_i[j-k];
         end
      end
   end

   // top k_eff lanes of this word spill into the next one
   always_comb begin
      int ke;
      ke = int'(k_eff_i);
      for (int j = 0; j < int'(LANES); j++) begin
         if (j < ke) begin
            carry_data_o[j*SYM_W +: SYM_W] = data_i[(int'(LANES)-ke+j)*SYM_W +: SYM_W];
            carry_ctl_o[j]                 = ctl_i[int'(LANES)-ke+j];
         end else begin
            carry_data_o[j*SYM_W +: SYM_W] = '0;
            carry_ctl_o[j]                 = 1'b0;
         end
      end
   end

endmodule

// File: rtl/rx_lo_ctrl.sv
module rx_lo_ctrl
   import rx_lo_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned LW    = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          word_sync_i,
   input  logic          hit_i,
   input  logic [LW-1:0] hit_lane_i,
   output logic          ins_o,
   output logic [LW-1:0] k_o,
   output logic [LW-1:0] k_eff_o,
   output logic          done_o
);

   logic          sync_q;
   logic          armed_q;
   logic          fixed_q;
   logic          pend_q;
   logic          done_q;
   logic [LW-1:0] k_q;
   logic          rise;
   logic          scan;
   logic          take;
   logic [LW-1:0] pads;

   assign rise    = word_sync_i & ~sync_q;
   assign scan    = (armed_q | rise) & ~fixed_q;
   assign take    = scan & hit_i;
   assign pads    = LW'(pads_for_lane(int'(hit_lane_i), LANES));
   assign ins_o   = take && (hit_lane_i != '0);
   assign k_eff_o = ins_o ? pads : k_q;
   assign k_o     = k_q;
   assign done_o  = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q  <= 1'b0;
         armed_q <= 1'b0;
         fixed_q <= 1'b0;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
         k_q     <= '0;
      end else begin
         sync_q <= word_sync_i;
         pend_q <= 1'b0;
         if (scan) armed_q <= 1'b1;
         if (take) begin
            fixed_q <= 1'b1;
            if (ins_o) begin
               k_q    <= pads;
               pend_q <= 1'b1;
            end else begin
               done_q <= 1'b1;
            end
         end
         if (pend_q) done_q <= 1'b1;
      end
   end

endmodule

// File: rtl/rx_lane_orderer.sv
module rx_lane_orderer #(
   parameter int unsigned          LANES     = 4,
   parameter int unsigned          SYM_W     = 10,
   parameter logic [SYM_W-1:0]     ALIGN_SYM = 10'h27C,
   parameter logic [SYM_W-1:0]     PAD_SYM   = 10'h1A5
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    word_sync_i,
   input  logic [LANES*SYM_W-1:0]  lane_data_i,
   input  logic [LANES-1:0]        lane_ctl_i,
   output logic [LANES*SYM_W-1:0]  lane_data_o,
   output logic [LANES-1:0]        lane_ctl_o,
   output logic                    order_done_o
);

   localparam int unsigned LW = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int unsigned DW = LANES * SYM_W;

   if (LANES < 2) begin : g_bad_lanes
      $error("rx_lane_orderer: LANES must be at least 2");
   end
   if (SYM_W < 2) begin : g_bad_width
      $error("rx_lane_orderer: SYM_W must be at least 2");
   end
   if (ALIGN_SYM == PAD_SYM) begin : g_bad_syms
      $error("rx_lane_orderer: pad symbol must differ from marker");
   end

   logic          hit;
   logic [LW-1:0] hit_lane;
   logic          ins;
   logic [LW-1:0] k_cur;
   logic [LW-1:0] k_eff;
   logic          done;
   logic [DW-1:0]    nxt_data, carry_data_q, nxt_carry_data;
   logic [LANES-1:0] nxt_ctl,  carry_ctl_q,  nxt_carry_ctl;

   rx_lo_detect #(.LANES(LANES), .SYM_W(SYM_W), .LW(LW), .ALIGN_SYM(ALIGN_SYM)) u_det (
      .data_i (lane_data_i),
      .ctl_i  (lane_ctl_i),
      .hit_o  (hit),
      .lane_o (hit_lane)
   );

   rx_lo_ctrl #(.LANES(LANES), .LW(LW)) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .word_sync_i (word_sync_i),
      .hit_i       (hit),
      .hit_lane_i  (hit_lane),
      .ins_o       (ins),
      .k_o         (k_cur),
      .k_eff_o     (k_eff),
      .done_o      (done)
   );

   rx_lo_shift #(.LANES(LANES), .SYM_W(SYM_W), .LW(LW), .PAD_SYM(PAD_SYM)) u_shift (
      .data_i       (lane_data_i),
      .ctl_i        (lane_ctl_i),
      .carry_data_i (carry_data_q),
      .carry_ctl_i  (carry_ctl_q),
      .ins_i        (ins),
      .lane_i       (hit_lane),
      .k_i          (k_cur),
      .k_eff_i      (k_eff),
      .data_o       (nxt_data),
      .ctl_o        (nxt_ctl),
      .carry_data_o (nxt_carry_data),
      .carry_ctl_o  (nxt_carry_ctl)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         lane_data_o  <= '0;
         lane_ctl_o   <= '0;
         carry_data_q <= '0;
         carry_ctl_q  <= '0;
      end else begin
         lane_data_o  <= nxt_data;
         lane_ctl_o   <= nxt_ctl;
         carry_data_q <= nxt_carry_data;
         carry_ctl_q  <= nxt_carry_ctl;
      end
   end

   assign order_done_o = done;

endmodule

// File: rtl/rx_lo_chk.sv
module rx_lo_chk #(
   parameter int unsigned          LANES     = 4,
   parameter int unsigned          SYM_W     = 10,
   parameter int unsigned          LW        = 2,
   parameter logic [SYM_W-1:0]     ALIGN_SYM = 10'h27C
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    word_sync_i,
   input logic [LANES*SYM_W-1:0]  lane_data_o,
   input logic [LANES-1:0]        lane_ctl_o,
   input logic                    order_done_o,
   input logic [LW-1:0]           k_cur
);

   logic sync_prev;
   logic rise_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_prev <= 1'b0;
         rise_seen <= 1'b0;
      end else begin
         sync_prev <= word_sync_i;
         if (word_sync_i && !sync_prev) rise_seen <= 1'b1;
      end
   end

   // R1: reset clears the outputs
   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> (order_done_o == 1'b0 && lane_ctl_o == '0 && lane_data_o == '0));

   // R3: completion is impossible without a prior sync rise
   assert_armed_by_rise_R3: assert property (@(posedge clk) disable iff (rst)
      order_done_o |-> rise_seen);

   // R4 / R5: when done rises, lane 0 holds the marker with its flag set
   assert_marker_in_lane0_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(order_done_o) |-> (lane_data_o[SYM_W-1:0] == ALIGN_SYM && lane_ctl_o[0]));

   // R6: done is sticky
   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      order_done_o |=> order_done_o);

   // R7: shift frozen once done
   assert_shift_frozen_R7: assert property (@(posedge clk) disable iff (rst)
      order_done_o |=> $stable(k_cur));

endmodule

bind rx_lane_orderer rx_lo_chk #(
   .LANES(LANES), .SYM_W(SYM_W), .LW(LW), .ALIGN_SYM(ALIGN_SYM)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .word_sync_i  (word_sync_i),
   .lane_data_o  (lane_data_o),
   .lane_ctl_o   (lane_ctl_o),
   .order_done_o (order_done_o),
   .k_cur        (k_cur)
);

// File: tb/sim_rx_lane_orderer.sv
`timescale 1ns/1ps
module sim_rx_lane_orderer;

   localparam int          LN  = 4;
   localparam int          SW  = 10;
   localparam logic [9:0]  MK  = 10'h27C;
   localparam logic [9:0]  PD  = 10'h1A5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sync_i = 1'b0;
   logic [39:0]   data_i = '0;
   logic [3:0]    ctl_i = '0;
   logic [39:0]   data_o;
   logic [3:0]    ctl_o;
   logic          done_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   rx_lane_orderer #(.LANES(LN), .SYM_W(SW), .ALIGN_SYM(MK), .PAD_SYM(PD)) u0 (
      .clk(clk), .rst(rst), .word_sync_i(sync_i),
      .lane_data_i(data_i), .lane_ctl_i(ctl_i),
      .lane_data_o(data_o), .lane_ctl_o(ctl_o), .order_done_o(done_o)
   );

   // reference model state: a symbol stream with pads spliced in
   logic [10:0] bq[$];
   bit m_sync, m_armed, m_fixed, m_pend, m_done;

   logic [39:0] eq_d[$];
   logic [3:0]  eq_c[$];
   logic        eq_a[$];
   string       eq_t[$];

   function automatic logic [39:0] w4(input logic [9:0] b3, b2, b1, b0);
      return {b3, b2, b1, b0};
   endfunction

   task automatic model_clear();
      bq.delete();
      m_sync = 0; m_armed = 0; m_fixed = 0; m_pend = 0; m_done = 0;
   endtask

   task automatic drive(input logic [39:0] d, input logic [3:0] c, input logic s,
                        input string tag);
      int L;
      bit rise, scan, nd;
      logic [39:0] ed;
      logic [3:0]  ec;
      logic [10:0] sy;
      @(negedge clk);
      data_i = d; ctl_i = c; sync_i = s;
      rise = s && !m_sync;
      m_sync = s;
      scan = (m_armed || rise) && !m_fixed;
      if (scan) m_armed = 1;
      L = -1;
      for (int j = LN - 1; j >= 0; j--)
         if (c[j] && d[j*SW +: SW] == MK) L = j;
      nd = m_done || m_pend;
      m_pend = 0;
      if (scan && L >= 0) begin
         m_fixed = 1;
         if (L == 0) nd = 1; else m_pend = 1;
      end
      for (int j = 0; j < LN; j++) begin
         if (scan && L > 0 && j == L)
            for (int p = 0; p < LN - L; p++) bq.push_back({1'b0, PD});
         bq.push_back({c[j], d[j*SW +: SW]});
      end
      m_done = nd;
      for (int j = 0; j < LN; j++) begin
         sy = bq.pop_front();
         ec[j] = sy[10];
         ed[j*SW +: SW] = sy[9:0];
      end
      eq_d.push_back(ed); eq_c.push_back(ec); eq_a.push_back(nd); eq_t.push_back(tag);
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #1;
      if (eq_d.size() > 0) begin
         logic [39:0] ed;
         logic [3:0]  ec;
         logic        ea;
         string       t;
         ed = eq_d.pop_front(); ec = eq_c.pop_front();
         ea = eq_a.pop_front(); t = eq_t.pop_front();
         n_chk++;
         if (data_o !== ed || ctl_o !== ec || done_o !== ea) begin
            n_fail++;
            $display("FAIL %s: data=%h ctl=%b done=%b expected data=%h ctl=%b done=%b",
                     t, data_o, ctl_o, done_o, ed, ec, ea);
         end
      end
   end

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst = 1; sync_i = 0; data_i = 40'hFF_FFFF_FFFF; ctl_i = 4'hF;
      repeat (2) @(negedge clk);
      n_chk++;
      if (data_o !== '0 || ctl_o !== '0 || done_o !== 1'b0) begin
         n_fail++;
         $display("FAIL %s: data=%h ctl=%b done=%b expected all zero", tag, data_o, ctl_o, done_o);
      end
      data_i = '0; ctl_i = '0;
      rst = 0;
      model_clear();
   endtask

   initial begin
      model_clear();
      do_reset("R1 reset state");

      // R2: marker present, no sync rise yet -> pass through
      drive(w4(10'h011, MK, 10'h012, 10'h013), 4'b0100, 1'b0, "R2 no arm");
      drive(w4(10'h021, 10'h022, 10'h023, MK), 4'b0001, 1'b0, "R2 no arm lane0");
      drive(w4(10'h031, 10'h032, 10'h033, 10'h034), 4'b1010, 1'b0, "R2 plain");

      // R3: rise arms, no marker yet
      drive(w4(10'h041, 10'h042, 10'h043, 10'h044), 4'b0000, 1'b1, "R3 rise");
      // R4: marker in lane 2 -> two pads
      drive(w4(10'h051, MK, 10'h053, 10'h054), 4'b0101, 1'b1, "R4 pad lane2");
      drive(w4(10'h061, 10'h062, 10'h063, 10'h064), 4'b1001, 1'b1, "R6 marker lane0");
      drive(w4(10'h071, 10'h072, 10'h073, 10'h074), 4'b0110, 1'b1, "R8 carry");
      // R7: later markers ignored
      drive(w4(10'h081, 10'h082, MK, 10'h084), 4'b0010, 1'b1, "R7 ignore");
      drive(w4(MK, 10'h092, 10'h093, MK), 4'b1001, 1'b0, "R7 ignore2");
      drive(w4(10'h0A1, 10'h0A2, 10'h0A3, 10'h0A4), 4'b0000, 1'b1, "R8 carry2");

      // R12: mid-stream reset clears shift and done
      do_reset("R12 reset mid-stream");
      drive(w4(10'h0B1, 10'h0B2, 10'h0B3, 10'h0B4), 4'b1100, 1'b0, "R12 passthru");
      drive(w4(10'h0C1, MK, 10'h0C3, 10'h0C4), 4'b0100, 1'b0, "R12 passthru marker");

      // R5: rise and marker in lane 0 in the same word
      drive(w4(10'h0D1, 10'h0D2, 10'h0D3, MK), 4'b0001, 1'b1, "R5 lane0");
      drive(w4(10'h0E1, 10'h0E2, 10'h0E3, 10'h0E4), 4'b0011, 1'b1, "R5 after");

      // R10 / R11
      do_reset("R1 reset again");
      drive(w4(10'h101, 10'h102, MK, 10'h104), 4'b0000, 1'b1, "R10 flag clear");
      drive(w4(MK, 10'h112, MK, 10'h114), 4'b1010, 1'b1, "R11 lowest lane");
      drive(w4(10'h121, 10'h122, 10'h123, 10'h124), 4'b0101, 1'b0, "R11 marker lane0");
      drive(w4(10'h131, 10'h132, 10'h133, 10'h134), 4'b1000, 1'b0, "R8 carry3");

      // R3 arming survives sync drop; R9 pad flags with marker in lane 3
      do_reset("R1 reset third");
      drive(w4(10'h141, 10'h142, 10'h143, 10'h144), 4'b1111, 1'b1, "R3 rise only");
      drive(w4(10'h151, 10'h152, 10'h153, 10'h154), 4'b0110, 1'b0, "R3 sync low");
      drive(w4(MK, 10'h162, 10'h163, 10'h164), 4'b1111, 1'b0, "R9 pad flag");
      drive(w4(10'h171, 10'h172, 10'h173, 10'h174), 4'b1110, 1'b0, "R9 marker lane0");
      drive(w4(10'h181, 10'h182, 10'h183, 10'h184), 4'b0001, 1'b0, "R8 carry4");

      @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule